// File: doc/BRIEF.md
# CAN Fault Confinement State and Interrupt Flags

This block follows the fault confinement state of a CAN node and raises sticky interrupt flags for the events software must see. The node's transmit and receive error counters come in from the counter logic. From them the block keeps a four-state machine: error active, error passive, bus-off and halted. While in bus-off it watches the received bus level once per bit time and counts runs of consecutive recessive bits. A fixed number of such runs completes bus-off recovery.

Three flags record events: an overload condition, any bus-off transition (entry, recovery or move to halt) and entry into error passive. Each flag stays set until software writes 1 to its bit. Writing 1 clears the flag even while the condition that set it still holds, so the current state is read from separate status outputs. An overload condition always sets its flag. A request to send an overload frame goes out only when the node may transmit. The interrupt line is the OR of the flags that are enabled.

Top module: `canFaultFlags`

## Requirements
- R1: While reset is asserted, and after it is released, flags, busOff, errPassive, halted and irq are all 0.
- R2: Outside bus-off and halt, errPassive is 1 in the cycle after an edge at which tec >= PASSIVE_LIMIT, rec >= PASSIVE_LIMIT or forcePassive is 1. Otherwise it is 0. The boundaries are 127 and 128.
- R3: Flag bit 0 (error passive) sets only on the move from error active into error passive. A passive condition that persists does not set it again after a clear.
- R4: When tec >= BUSOFF_LIMIT (boundary 255/256) outside bus-off and halt, the node enters bus-off: busOff goes to 1, errPassive goes to 0, and flag bit 1 (bus-off) sets. In bus-off the counters are then ignored.
- R5: In bus-off, every bitStrobe with rxLevel=1 (recessive) advances a run count, and a strobe with rxLevel=0 restarts the run at zero. When RUN_COUNT runs of RUN_LEN recessive samples are complete, busOff goes to 0, the node is error active, and flag bit 1 sets again. The counts restart on each bus-off entry.
- R6: haltReq in bus-off moves the node to halt (halted=1, busOff=0) and sets flag bit 1. Halt has priority over recovery. Halt is left for error active once haltReq is 0.
- R7: overloadPulse sets flag bit 2 (overload) whether or not listenOnly is set. ovlTxReq equals overloadPulse only when listenOnly is 0 and the node is neither bus-off nor halted. Otherwise ovlTxReq is 0.
- R8: A write (wrEn=1) clears every flag whose wrData bit is 1, even while its condition persists. wrData bits that are 0 leave their flags unchanged.
- R9: If a set event and a write-1 clear hit the same flag in the same cycle, the flag ends up set.
- R10: irq is 1 exactly when some flag bit and the same bit of intEnable are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tec | input | CNT_W | Transmit error count |
| rec | input | CNT_W | Receive error count |
| haltReq | input | 1 | Request to move from bus-off to halt |
| forcePassive | input | 1 | Test mode: force error passive |
| listenOnly | input | 1 | Listen-only mode, transmission inhibited |
| bitStrobe | input | 1 | One pulse per bit time |
| rxLevel | input | 1 | Sampled bus level, 1 = recessive |
| overloadPulse | input | 1 | Overload condition detected |
| wrEn | input | 1 | Flag register write strobe |
| wrData | input | 3 | Write-1-to-clear mask {overload, bus-off, passive} |
| intEnable | input | 3 | Per-flag interrupt enables, same bit order |
| flags | output | 3 | Sticky flags {overload, bus-off, passive} |
| busOff | output | 1 | Node is in bus-off |
| errPassive | output | 1 | Node is error passive |
| halted | output | 1 | Node is halted |
| ovlTxReq | output | 1 | Request to transmit an overload frame |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with RUN_LEN=3 and RUN_COUNT=4, and keeps the default 9-bit counters and the limits of 128 and 256. With these values a full recovery takes twelve recessive samples, so the run wrap, the run-count wrap and a dominant restart in the middle of a run all fit in a short directed sequence. The default limits keep the 127/128 and 255/256 boundaries exactly as the block will see them.

// File: rtl/canFaultPkg.sv
package canFaultPkg;
  localparam int NUM_FLAGS = 3;
  localparam int FLAG_PASSIVE = 0;
  localparam int FLAG_BUSOFF = 1;
  localparam int FLAG_OVERLOAD = 2;

  typedef enum logic [1:0] {
    ST_ACTIVE  = 2'd0,
    ST_PASSIVE = 2'd1,
    ST_BUSOFF  = 2'd2,
    ST_HALT    = 2'd3
  } nodeStateT;

  // packed MSB first so that a cast lines up with the flag indices
  typedef struct packed {
    logic overload;
    logic busOff;
    logic passive;
  } flagSetT;
endpackage

// File: rtl/canFaultCtrl.sv
module canFaultCtrl
  import canFaultPkg::*;
#(
  parameter int CNT_W = 9,
  parameter int PASSIVE_LIMIT = 128,
  parameter int BUSOFF_LIMIT = 256,
  parameter int RUN_LEN = 11,
  parameter int RUN_COUNT = 128
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] tec,
  input  logic [CNT_W-1:0] rec,
  input  logic             haltReq,
  input  logic             forcePassive,
  input  logic             listenOnly,
  input  logic             bitStrobe,
  input  logic             rxLevel,
  input  logic             overloadPulse,
  output flagSetT          setStrobes,
  output logic             busOff,
  output logic             errPassive,
  output logic             halted,
  output logic             ovlTxReq
);
  localparam int RUN_W = $clog2(RUN_LEN + 1);
  localparam int SEQ_W = $clog2(RUN_COUNT + 1);
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(RUN_LEN - 1);
  localparam logic [SEQ_W-1:0] SEQ_LAST = SEQ_W'(RUN_COUNT - 1);
  localparam logic [CNT_W-1:0] PASS_TH = CNT_W'(PASSIVE_LIMIT);
  localparam logic [CNT_W-1:0] OFF_TH = CNT_W'(BUSOFF_LIMIT);

  nodeStateT state, nextState;
  logic [RUN_W-1:0] runCnt, runNext;
  logic [SEQ_W-1:0] seqCnt, seqNext;
  logic passiveCond, offCond, canTransmit;

  assign passiveCond = (tec >= PASS_TH) || (rec >= PASS_TH) || forcePassive;
  assign offCond = (tec >= OFF_TH);

  always_comb begin
    nextState = state;
    runNext = runCnt;
    seqNext = seqCnt;
    setStrobes = '0;
    setStrobes.overload = overloadPulse;
    case (state)
      ST_ACTIVE, ST_PASSIVE: begin
        if (offCond) begin
          nextState = ST_BUSOFF;
          setStrobes.busOff = 1'b1;
          runNext = '0;
          seqNext = '0;
        end else if (passiveCond) begin
          nextState = ST_PASSIVE;
          setStrobes.passive = (state == ST_ACTIVE);
        end else begin
          nextState = ST_ACTIVE;
        end
      end
      ST_BUSOFF: begin
        if (haltReq) begin
          nextState = ST_HALT;
          setStrobes.busOff = 1'b1;
        end else if (bitStrobe) begin
          if (!rxLevel) begin
            runNext = '0;
          end else if (runCnt == RUN_LAST) begin
            runNext = '0;
            if (seqCnt == SEQ_LAST) begin
              seqNext = '0;
              nextState = ST_ACTIVE;
              setStrobes.busOff = 1'b1;
            end else begin
              seqNext = seqCnt + 1'b1;
            end
          end else begin
            runNext = runCnt + 1'b1;
          end
        end
      end
      default: begin
        if (!haltReq) nextState = ST_ACTIVE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_ACTIVE;
      runCnt <= '0;
      seqCnt <= '0;
    end else begin
      state <= nextState;
      runCnt <= runNext;
      seqCnt <= seqNext;
    end
  end

  assign busOff = (state == ST_BUSOFF);
  assign errPassive = (state == ST_PASSIVE);
  assign halted = (state == ST_HALT);
  assign canTransmit = (state == ST_ACTIVE) || (state == ST_PASSIVE);
  assign ovlTxReq = overloadPulse && !listenOnly && canTransmit;
endmodule

// File: rtl/canFaultFlagsDp.sv
module canFaultFlagsDp
  import canFaultPkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  flagSetT              setStrobes,
  input  logic                 wrEn,
  input  logic [NUM_FLAGS-1:0] wrData,
  input  logic [NUM_FLAGS-1:0] intEnable,
  output logic [NUM_FLAGS-1:0] flags,
  output logic                 irq
);
  logic [NUM_FLAGS-1:0] setVec;
  assign setVec = setStrobes;

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    logic clearHit;
    assign clearHit = wrEn && wrData[i];
    always_ff @(posedge clk) begin
      if (!rstN) flags[i] <= 1'b0;
      else if (setVec[i]) flags[i] <= 1'b1;
      else if (clearHit) flags[i] <= 1'b0;
    end
  end

  assign irq = |(flags & intEnable);
endmodule

// File: rtl/canFaultFlags.sv
module canFaultFlags
  import canFaultPkg::*;
#(
  parameter int CNT_W = 9,
  parameter int PASSIVE_LIMIT = 128,
  parameter int BUSOFF_LIMIT = 256,
  parameter int RUN_LEN = 11,
  parameter int RUN_COUNT = 128
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] tec,
  input  logic [CNT_W-1:0] rec,
  input  logic             haltReq,
  input  logic             forcePassive,
  input  logic             listenOnly,
  input  logic             bitStrobe,
  input  logic             rxLevel,
  input  logic             overloadPulse,
  input  logic             wrEn,
  input  logic [2:0]       wrData,
  input  logic [2:0]       intEnable,
  output logic [2:0]       flags,
  output logic             busOff,
  output logic             errPassive,
  output logic             halted,
  output logic             ovlTxReq,
  output logic             irq
);
  flagSetT setStrobes;

  canFaultCtrl #(
    .CNT_W(CNT_W), .PASSIVE_LIMIT(PASSIVE_LIMIT), .BUSOFF_LIMIT(BUSOFF_LIMIT),
    .RUN_LEN(RUN_LEN), .RUN_COUNT(RUN_COUNT)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .tec(tec), .rec(rec), .haltReq(haltReq),
    .forcePassive(forcePassive), .listenOnly(listenOnly), .bitStrobe(bitStrobe),
    .rxLevel(rxLevel), .overloadPulse(overloadPulse), .setStrobes(setStrobes),
    .busOff(busOff), .errPassive(errPassive), .halted(halted), .ovlTxReq(ovlTxReq)
  );

  canFaultFlagsDp u_dp (
    .clk(clk), .rstN(rstN), .setStrobes(setStrobes), .wrEn(wrEn),
    .wrData(wrData), .intEnable(intEnable), .flags(flags), .irq(irq)
  );
endmodule

// File: rtl/canFaultFlagsChk.sv
module canFaultFlagsChk #(
  parameter int CNT_W = 9,
  parameter int BUSOFF_LIMIT = 256
) (
  input logic             clk,
  input logic             rstN,
  input logic [CNT_W-1:0] tec,
  input logic             haltReq,
  input logic             listenOnly,
  input logic             overloadPulse,
  input logic             wrEn,
  input logic [2:0]       wrData,
  input logic [2:0]       intEnable,
  input logic [2:0]       flags,
  input logic             busOff,
  input logic             errPassive,
  input logic             halted,
  input logic             ovlTxReq,
  input logic             irq
);
  localparam logic [CNT_W-1:0] OFF_TH = CNT_W'(BUSOFF_LIMIT);

  p_state_excl_r2: assert property (@(posedge clk) disable iff (!rstN)
    $countones({busOff, errPassive, halted}) <= 1);

  p_passive_rise_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errPassive) |-> flags[0]);

  p_busoff_entry_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!busOff && !halted && tec >= OFF_TH) |=> (busOff && flags[1]));

  p_halt_r6: assert property (@(posedge clk) disable iff (!rstN)
    (busOff && haltReq) |=> (halted && flags[1]));

  p_listen_no_tx_r7: assert property (@(posedge clk) disable iff (!rstN)
    listenOnly |-> !ovlTxReq);

  p_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrData[2] && !overloadPulse) |=> !flags[2]);

  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rstN)
    overloadPulse |=> flags[2]);

  p_irq_masked_r10: assert property (@(posedge clk) disable iff (!rstN)
    (intEnable == 3'b000) |-> !irq);
endmodule

bind canFaultFlags canFaultFlagsChk #(.CNT_W(CNT_W), .BUSOFF_LIMIT(BUSOFF_LIMIT)) u_chk (
  .clk(clk), .rstN(rstN), .tec(tec), .haltReq(haltReq), .listenOnly(listenOnly),
  .overloadPulse(overloadPulse), .wrEn(wrEn), .wrData(wrData), .intEnable(intEnable),
  .flags(flags), .busOff(busOff), .errPassive(errPassive), .halted(halted),
  .ovlTxReq(ovlTxReq), .irq(irq)
);

// File: tb/canFaultFlags_tb.sv
module canFaultFlags_tb;
  localparam int CNT_W = 9;
  localparam int RUN_LEN = 3;
  localparam int RUN_COUNT = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [CNT_W-1:0] tec = '0, rec = '0;
  logic haltReq = 0, forcePassive = 0, listenOnly = 0, bitStrobe = 0, rxLevel = 1;
  logic overloadPulse = 0, wrEn = 0;
  logic [2:0] wrData = '0, intEnable = '0;
  logic [2:0] flags;
  logic busOff, errPassive, halted, ovlTxReq, irq;

  int nChecks = 0;
  int nFails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  canFaultFlags #(.CNT_W(CNT_W), .RUN_LEN(RUN_LEN), .RUN_COUNT(RUN_COUNT)) u_dut (
    .clk(clk), .rstN(rstN), .tec(tec), .rec(rec), .haltReq(haltReq),
    .forcePassive(forcePassive), .listenOnly(listenOnly), .bitStrobe(bitStrobe),
    .rxLevel(rxLevel), .overloadPulse(overloadPulse), .wrEn(wrEn), .wrData(wrData),
    .intEnable(intEnable), .flags(flags), .busOff(busOff), .errPassive(errPassive),
    .halted(halted), .ovlTxReq(ovlTxReq), .irq(irq)
  );

  typedef struct packed {
    logic [8:0] vTec;
    logic [8:0] vRec;
    logic       vForce;
    logic       vOvl;
    logic       vListen;
    logic       vWr;
    logic [2:0] vData;
    logic [2:0] eFlags;
    logic       eBo;
    logic       eEp;
    logic       eTx;
  } vecT;

  localparam int NVEC = 18;
  // flags order {overload, bus-off, passive}
  localparam vecT VECS [NVEC] = '{
    '{9'd0,   9'd0,   1'b0, 1'b0, 1'b0, 1'b0, 3'b000, 3'b000, 1'b0, 1'b0, 1'b0}, // R2 idle
    '{9'd127, 9'd0,   1'b0, 1'b0, 1'b0, 1'b0, 3'b000, 3'b000, 1'b0, 1'b0, 1'b0}, // R2 just below
    '{9'd128, 9'd0,   1'b0, 1'b0, 1'b0, 1'b0, 3'b000, 3'b001, 1'b0, 1'b1, 1'b0}, // R2 R3 rise
    '{9'd128, 9'd0,   1'b0, 1'b0, 1'b0, 1'b0, 3'b000, 3'b001, 1'b0, 1'b1, 1'b0}, // R3 held
    '{9'd128, 9'd0,   1'b0, 1'b0, 1'b0, 1'b1, 3'b001, 3'b000, 1'b0, 1'b1, 1'b0}, // R8 clear while persists
    '{9'd128, 9'd0,   1'b0, 1'b0, 1'b0, 1'b0, 3'b000, 3'b000, 1'b0, 1'b1, 1'b0}, // R3 no re-set
    '{9'd0,   9'd128, 1'b0, 1'b0, 1'b0, 1'b0, 3'b000, 3'b000, 1'b0, 1'b1, 1'b0}, // R2 rec source
    '{9'd0,   9'd127, 1'b0, 1'b0, 1'b0, 1'b0, 3'b000, 3'b000, 1'b0, 1'b0, 1'b0}, // R2 back active
    '{9'd0,   9'd0,   1'b1, 1'b0, 1'b0, 1'b0, 3'b000, 3'b001, 1'b0, 1'b1, 1'b0}, // R2 R3 forced
    '{9'd0,   9'd0,   1'b0, 1'b0, 1'b0, 1'b1, 3'b000, 3'b001, 1'b0, 1'b0, 1'b0}, // R8 write 0
    '{9'd0,   9'd0,   1'b0, 1'b1, 1'b1, 1'b0, 3'b000, 3'b101, 1'b0, 1'b0, 1'b0}, // R7 listen-only
    '{9'd0,   9'd0,   1'b0, 1'b0, 1'b0, 1'b1, 3'b100, 3'b001, 1'b0, 1'b0, 1'b0}, // R8
    '{9'd0,   9'd0,   1'b0, 1'b1, 1'b0, 1'b1, 3'b100, 3'b101, 1'b0, 1'b0, 1'b1}, // R9 R7 tx
    '{9'd0,   9'd0,   1'b0, 1'b0, 1'b0, 1'b1, 3'b111, 3'b000, 1'b0, 1'b0, 1'b0}, // R8 all
    '{9'd255, 9'd0,   1'b0, 1'b0, 1'b0, 1'b0, 3'b000, 3'b001, 1'b0, 1'b1, 1'b0}, // R4 just below
    '{9'd256, 9'd0,   1'b0, 1'b0, 1'b0, 1'b0, 3'b000, 3'b011, 1'b1, 1'b0, 1'b0}, // R4 entry
    '{9'd300, 9'd0,   1'b0, 1'b0, 1'b0, 1'b1, 3'b010, 3'b001, 1'b1, 1'b0, 1'b0}, // R8 clear in bus-off
    '{9'd0,   9'd0,   1'b0, 1'b0, 1'b0, 1'b1, 3'b001, 3'b000, 1'b1, 1'b0, 1'b0}  // R4 stays bus-off
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic sample(logic level);
    bitStrobe = 1'b1;
    rxLevel = level;
    @(negedge clk);
    bitStrobe = 1'b0;
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endtask

  initial begin
    int wd = 0;
    while (!done) begin
      @(posedge clk);
      wd++;
      if (wd > 20000) begin
        nChecks++;
        nFails++;
        $display("FAIL watchdog: actual %0d expected < 20000 cycles", wd);
        finishRun();
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 flags in reset", 32'(flags), 0);
    check("R1 status in reset", 32'({busOff, errPassive, halted, irq}), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 flags after reset", 32'(flags), 0);

    for (int i = 0; i < NVEC; i++) begin
      tec = VECS[i].vTec; rec = VECS[i].vRec; forcePassive = VECS[i].vForce;
      overloadPulse = VECS[i].vOvl; listenOnly = VECS[i].vListen;
      wrEn = VECS[i].vWr; wrData = VECS[i].vData;
      @(negedge clk);
      check($sformatf("R2/R3/R4/R7/R8/R9 vec %0d flags", i), 32'(flags), 32'(VECS[i].eFlags));
      check($sformatf("R4 vec %0d busOff", i), 32'(busOff), 32'(VECS[i].eBo));
      check($sformatf("R2 vec %0d errPassive", i), 32'(errPassive), 32'(VECS[i].eEp));
      check($sformatf("R7 vec %0d ovlTxReq", i), 32'(ovlTxReq), 32'(VECS[i].eTx));
    end
    tec = '0; rec = '0; forcePassive = 0; overloadPulse = 0; listenOnly = 0; wrEn = 0; wrData = '0;

    // R5: two recessive, dominant restarts, then 11 recessive: not yet recovered
    sample(1'b1); sample(1'b1); sample(1'b0);
    for (int k = 0; k < RUN_LEN * RUN_COUNT - 1; k++) sample(1'b1);
    check("R5 still bus-off one sample short", 32'(busOff), 1);
    check("R5 flag not yet set", 32'(flags), 0);
    sample(1'b1);
    check("R5 recovered busOff", 32'(busOff), 0);
    check("R5 recovery sets bus-off flag", 32'(flags), 3'b010);
    check("R5 active after recovery", 32'(errPassive), 0);

    // R6 halt from bus-off
    wrEn = 1; wrData = 3'b010; tec = 9'd256;
    @(negedge clk);
    wrEn = 0; tec = '0;
    check("R4 re-entry", 32'(busOff), 1);
    wrEn = 1; wrData = 3'b010; bitStrobe = 1; rxLevel = 1; haltReq = 1;
    @(negedge clk);
    wrEn = 0; bitStrobe = 0;
    check("R6 halted", 32'({halted, busOff}), 2'b10);
    check("R6 halt sets flag over clear", 32'(flags), 3'b010);
    overloadPulse = 1;
    @(negedge clk);
    check("R7 no tx request in halt", 32'(ovlTxReq), 0);
    overloadPulse = 0;
    check("R7 overload flag in halt", 32'(flags), 3'b110);
    haltReq = 0;
    @(negedge clk);
    check("R6 halt left", 32'({halted, busOff, errPassive}), 0);

    // R10 interrupt gating, flags = 110
    intEnable = 3'b000; #1 check("R10 all masked", 32'(irq), 0);
    intEnable = 3'b001; #1 check("R10 only clear flag enabled", 32'(irq), 0);
    intEnable = 3'b100; #1 check("R10 overload enabled", 32'(irq), 1);
    intEnable = 3'b010; #1 check("R10 bus-off enabled", 32'(irq), 1);
    @(negedge clk);

    // R1 reset mid-run
    rstN = 0; tec = 9'd300;
    @(negedge clk);
    check("R1 flags cleared by reset", 32'(flags), 0);
    check("R1 status cleared by reset", 32'({busOff, errPassive, halted, irq}), 0);
    tec = '0; rstN = 1;
    @(negedge clk);
    check("R1 idle after reset", 32'({flags, busOff, errPassive}), 0);

    done = 1;
    finishRun();
  end
endmodule